// File: doc/BRIEF.md
# Synchronous Shift-Register Expansion Port

This block is a half-duplex synchronous serial port for hanging standard TTL or CMOS shift registers off a chip to add I/O lines. It drives a shift clock on a dedicated output pin and uses a single bidirectional data pin. The data pin is driven during a transmit and released and sampled during a receive. Every transfer moves one byte, least significant bit first. Each bit takes a fixed period of twelve system clocks, so the bit rate is the system clock divided by 12.

A transmit starts with a one-cycle byte write. A receive starts with a one-cycle receive command. Either command is accepted only while the port is idle. When the eighth bit period ends, the port returns to idle and raises a done flag. After a receive, the assembled byte is held on a parallel output until the next receive completes.

Top module: `sio_expander`

## Requirements
- R1: After reset and whenever idle, `sclk` is 1, `sdat_oe` is 0 and, out of reset, `done` is 0.
- R2: A `wr_en` pulse while idle starts a transmit of `wr_data`. Bit k of the byte (k = 0 first) is on `sdat_o` at the k-th rising edge of `sclk`, and `sdat_oe` is 1 in every cycle of the transfer.
- R3: Each bit period is 12 clocks: `sclk` is 0 for 6 clocks and then 1 for 6 clocks. If the command is sampled at clock edge E0, the k-th rise of `sclk` shows after edge E0+12k+6.
- R4: An `rx_start` pulse while idle starts a receive with `sdat_oe` at 0. `sdat_i` is sampled in the clock just before each rise of `sclk`, LSB first. The byte appears on `rx_data` when `done` rises.
- R5: `done` is 0 throughout a transfer and becomes 1 after clock edge E0+96. It then stays 1 until the next accepted command.
- R6: `wr_en` or `rx_start` that arrives during a transfer is ignored: the byte shifted out or in and the transfer timing are unchanged.
- R7: If `wr_en` and `rx_start` arrive together while idle, the port transmits.
- R8: `rx_data` is left unchanged by a transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write, starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rx_start | input | 1 | Starts a receive |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | Transfer complete flag |
| sclk | output | 1 | Shift clock to external registers |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| sdat_i | input | 1 | Data pin input value |

## Verification
The hardest case to reach from the ports is a second command that lands in the middle of a transfer. The stimulus must hold the port busy and then pulse both command inputs at once, with an inverted write byte, partway through the third bit. The bench does this on alternate transfers of its sweep. It then checks that the shifted byte, the rise times of the clock and the done timing all match those of an undisturbed transfer. Both directions are swept over all 256 byte values. For receives, the bench models the external register and presents the next bit on each falling clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } sio_mode_e;
endpackage

// File: rtl/sio_timebase.sv
module sio_timebase #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic low_phase,
    output logic sample,
    output logic bit_end
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] div;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || st_q.div == CW'(DIV - 1))
            st_d.div = '0;
        else
            st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_phase = st_q.div < CW'(HALF);
    assign sample    = st_q.div == CW'(HALF - 1);
    assign bit_end   = st_q.div == CW'(DIV - 1);

    // R3: the period counter wraps to zero after the last cycle of a bit
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> st_q.div == '0);
    // R3: an idle timebase never advances
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.div == '0);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         take_in,
    input  logic         din,
    input  logic         push_out,
    input  logic         bit_end,
    output logic         last_bit,
    output logic         lsb,
    output logic [W-1:0] word
);
    localparam int BW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [BW-1:0] cnt;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr  = load_val;
            st_d.cnt = '0;
        end else begin
            if (take_in)
                st_d.sr = {din, st_q.sr[W-1:1]};
            else if (push_out)
                st_d.sr = {1'b0, st_q.sr[W-1:1]};
            if (bit_end)
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_bit = st_q.cnt == BW'(W - 1);
    assign lsb      = st_q.sr[0];
    assign word     = st_q.sr;

    // R2: a loaded transfer begins at bit zero
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.cnt == '0);
endmodule

// File: rtl/sio_expander.sv
module sio_expander #(
    parameter int W   = 8,
    parameter int DIV = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rx_start,
    output logic [W-1:0] rx_data,
    output logic         done,
    output logic         sclk,
    output logic         sdat_o,
    output logic         sdat_oe,
    input  logic         sdat_i
);
    import sio_pkg::*;

    typedef struct packed {
        sio_mode_e    mode;
        logic         done;
        logic [W-1:0] rxb;
    } top_state_t;

    top_state_t st_d, st_q;

    logic         busy, low_phase, sample, bit_end, last_bit, lsb;
    logic         start_tx, start_rx, finish;
    logic [W-1:0] word;

    assign busy     = st_q.mode != MODE_IDLE;
    assign start_tx = !busy && wr_en;
    assign start_rx = !busy && rx_start && !wr_en;
    assign finish   = busy && bit_end && last_bit;

    sio_timebase #(.DIV(DIV)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .low_phase (low_phase),
        .sample    (sample),
        .bit_end   (bit_end)
    );

    sio_shifter #(.W(W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_tx || start_rx),
        .load_val (start_tx ? wr_data : '0),
        .take_in  (st_q.mode == MODE_RX && sample),
        .din      (sdat_i),
        .push_out (st_q.mode == MODE_TX && bit_end),
        .bit_end  (busy && bit_end),
        .last_bit (last_bit),
        .lsb      (lsb),
        .word     (word)
    );

    always_comb begin
        st_d = st_q;
        if (start_tx) begin
            st_d.mode = MODE_TX;
            st_d.done = 1'b0;
        end else if (start_rx) begin
            st_d.mode = MODE_RX;
            st_d.done = 1'b0;
        end else if (finish) begin
            st_d.mode = MODE_IDLE;
            st_d.done = 1'b1;
            if (st_q.mode == MODE_RX)
                st_d.rxb = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_IDLE;
            st_q.done <= 1'b0;
            st_q.rxb  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk    = busy ? !low_phase : 1'b1;
    assign sdat_oe = st_q.mode == MODE_TX;
    assign sdat_o  = sdat_oe && lsb;
    assign done    = st_q.done;
    assign rx_data = st_q.rxb;

    // R1: an idle port holds the clock high and releases the data pin
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk && !sdat_oe);
    // R4: the data pin is never driven during a receive
    p_rx_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_RX |-> !sdat_oe);
    // R5: done only rises at the end of a transfer
    p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && !busy);
    // R6: a running transfer keeps its direction until it finishes
    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish |=> st_q.mode == $past(st_q.mode));
    // R8: a transmit leaves the received byte alone
    p_rx_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_TX |=> $stable(rx_data));
endmodule

// File: tb/sim_sio_expander.sv
module sim_sio_expander;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx_start = 1'b0;
    logic [7:0] rx_data;
    logic       done, sclk, sdat_o, sdat_oe;
    logic       sdat_i = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] last_rx = 8'h00;

    always #5 clk = ~clk;

    sio_expander u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rx_start(rx_start), .rx_data(rx_data), .done(done), .sclk(sclk),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // is_rx: receive; both: raise both commands; inject: mid-transfer commands
    task automatic xfer(input bit is_rx, input bit both, input bit inject, input logic [7:0] data);
        logic [7:0] got = 8'h00;
        int  rises = 0, falls = 0;
        bit  time_ok = 1, oe_ok = 1, done_ok = 1;
        logic prev = 1'b1;
        wr_en    = !is_rx || both;
        wr_data  = data;
        rx_start = is_rx || both;
        for (int n = 1; n <= 97; n++) begin
            @(negedge clk);
            if (n == 1) begin wr_en = 1'b0; rx_start = 1'b0; end
            if (n == 30 && inject) begin
                wr_en = 1'b1; rx_start = 1'b1; wr_data = ~data;
            end
            if (n == 31) begin wr_en = 1'b0; rx_start = 1'b0; end
            if (n <= 96) begin
                if (sdat_oe !== !is_rx) oe_ok = 0;
                if (done !== 1'b0) done_ok = 0;
                if (sclk && !prev) begin
                    if (n != 12 * rises + 7) time_ok = 0;
                    if (rises < 8) got[rises] = sdat_o;
                    rises++;
                end
                if (!sclk && prev) begin
                    if (n != 12 * falls + 1) time_ok = 0;
                    if (falls < 8) sdat_i = data[falls];
                    falls++;
                end
                prev = sclk;
            end
        end
        chk(time_ok && rises == 8 && falls == 8, "R3 clock timing", rises, 8);
        chk(done_ok && done === 1'b1, "R5 done timing", done, 1);
        chk(sclk === 1'b1 && sdat_oe === 1'b0, "R1 idle after transfer", {sclk, sdat_oe}, 2);
        if (is_rx) begin
            chk(oe_ok, inject ? "R6 rx tristate" : "R4 rx tristate", 1, 0);
            chk(rx_data === data, inject ? "R6 rx byte" : "R4 rx byte", rx_data, data);
            last_rx = data;
        end else begin
            chk(oe_ok, "R2 tx enable", 0, 1);
            chk(got === data, both ? "R7 tx wins" : (inject ? "R6 tx byte" : "R2 tx byte"), got, data);
            chk(rx_data === last_rx, "R8 rx_data kept", rx_data, last_rx);
        end
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk === 1'b1 && sdat_oe === 1'b0 && done === 1'b0, "R1 reset state",
            {sclk, sdat_oe, done}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk === 1'b1 && sdat_oe === 1'b0, "R1 idle out of reset", {sclk, sdat_oe}, 2);
        for (int b = 0; b < 256; b++) xfer(1'b1, 1'b0, b[0], 8'(b));
        for (int b = 0; b < 256; b++) xfer(1'b0, 1'b0, b[0], 8'(b ^ 8'h5a));
        xfer(1'b0, 1'b1, 1'b0, 8'hc3);
        xfer(1'b0, 1'b1, 1'b1, 8'h81);
        chk(done === 1'b1, "R5 done held", done, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule